// File: doc/BRIEF.md
# I2C Engine Ownership Arbiter

This block decides who may use a single shared I2C master engine: a software requester or an autonomous hardware requester. Software asks for the engine with a one-cycle go pulse and gives it back with a one-cycle done pulse. The hardware requester holds a level request for as long as it needs the engine. The arbiter publishes a two-bit owner code, one grant line per requester, and a one-cycle start strobe each time software gains the engine. The bit-level engine itself sits outside the block. Software is expected to begin its job on the start strobe and finish it with the done pulse.

Three static settings shape the arbitration. The priority setting decides whether hardware may take the engine away from software. The restart setting decides whether a software job that hardware interrupted is resumed automatically once hardware lets go. The no-queue setting decides whether a software go that arrives while hardware owns the engine is kept waiting or thrown away. Software also has a soft-reset pulse that drops its own ownership. It acts only while software holds the engine.

All outputs are registered and update on the clock edge that samples the causing input. A synchronous active-high reset returns the block to idle.

Top module: `i2c_eng_arb`

## Requirements
- R1: The owner code `owner_status` is 0 for idle, 1 for software and 2 for hardware; the value 3 never appears; after reset the code is 0 and both grants are low.
- R2: The priority input `cfg_prio` is 0 for normal and 1 for high. From idle, a software go with no hardware request gives code 1 on the next edge. If the go and a hardware request arrive together, hardware wins at normal priority and software wins at high priority.
- R3: A software done pulse while software owns the engine gives code 0 on the next edge. A done pulse in any other state has no effect.
- R4: At normal priority, a hardware request while software owns the engine gives code 2 on the next edge. This is a pre-emption.
- R5: At high priority, a hardware request does not displace software. After the software done pulse the code is 0 for one edge, and then 2 on the following edge if hardware is still requesting.
- R6: With `cfg_restart_en` = 1, a software job that hardware pre-empted gets code 1 back on the edge that samples the hardware request low. This happens even when `cfg_no_queue` = 1.
- R7: With `cfg_restart_en` = 0 and nothing waiting, a pre-empted job is not resumed, and the code goes to 0 when hardware releases.
- R8: With `cfg_no_queue` = 1, a software go that arrives while hardware owns the engine is discarded. The code reaches 0, not 1, when hardware releases, unless R6 applies.
- R9: With `cfg_no_queue` = 0, a software go that arrives while hardware owns the engine is held. It gives code 1 on the edge that samples the hardware request low.
- R10: A soft-reset pulse while software owns the engine gives code 0 on the next edge. In idle or while hardware owns the engine, the code is unchanged.
- R11: The grant outputs are registered and at most one is high. `grant_sw` is high exactly when the code is 1, and `grant_hw` is high exactly when the code is 2.
- R12: `eng_start` is high for exactly one cycle, on the edge where the code changes to 1 from any other value, including an automatic restart.
- R13: A software go while software already owns the engine is ignored and is not remembered. After the following done pulse the code stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_go | input | 1 | Software request pulse |
| sw_done | input | 1 | Software release pulse |
| sw_reset | input | 1 | Software soft-reset pulse |
| hw_req | input | 1 | Hardware request level |
| cfg_prio | input | 1 | Software priority: 0 normal, 1 high |
| cfg_restart_en | input | 1 | Resume a pre-empted software job after hardware releases |
| cfg_no_queue | input | 1 | Discard software go while hardware owns the engine |
| owner_status | output | 2 | Owner code: 0 idle, 1 software, 2 hardware |
| grant_sw | output | 1 | Engine granted to software |
| grant_hw | output | 1 | Engine granted to hardware |
| eng_start | output | 1 | One-cycle strobe when software gains the engine |

## Verification
Every result here is due on the first clock edge that samples its cause: a grant, a release, a pre-emption, a restart or a start strobe. The one exception is the high-priority handover in R5, which passes through idle and takes two edges. The bench changes inputs a quarter period after a rising edge and reads the outputs a quarter period after the next rising edge, so each check looks at the edge where the result is due. For R5 and R9 the bench also checks the intermediate edge, which shows that nothing arrives early or late.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;

    localparam int unsigned OWNER_W = 2;

    typedef enum logic [OWNER_W-1:0] {
        OWN_IDLE = 2'd0,
        OWN_SW   = 2'd1,
        OWN_HW   = 2'd2
    } owner_e;

    typedef enum logic {
        PRIO_NORMAL = 1'b0,
        PRIO_HIGH   = 1'b1
    } prio_e;

    typedef struct packed {
        prio_e prio;
        logic  restart_en;
        logic  no_queue;
    } arb_cfg_t;

    typedef struct packed {
        logic go;
        logic done;
        logic sreset;
    } sw_cmd_t;

    // Hardware may displace software only at normal priority.
    function automatic logic hw_may_preempt(input prio_e p);
        return (p == PRIO_NORMAL);
    endfunction

    // Software leaves ownership on either a release or a soft reset.
    function automatic logic sw_lets_go(input sw_cmd_t c);
        return c.done | c.sreset;
    endfunction

endpackage

// File: rtl/i2c_arb_req.sv
module i2c_arb_req
    import i2c_arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   go,
    input  logic   no_queue,
    input  owner_e owner,
    input  owner_e owner_nx,
    output logic   pending
);

    logic pend_q;
    logic take_sw;
    logic lost_go;

    // Ownership moving to software consumes any waiting request.
    assign take_sw = (owner_nx == OWN_SW) && (owner != OWN_SW);
    // A go that is not served and does not land on an owning software.
    assign lost_go = go && (owner != OWN_SW) && (owner_nx != OWN_SW);

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (take_sw)
            pend_q <= 1'b0;
        else if (lost_go && !no_queue)
            pend_q <= 1'b1;
    end

    assign pending = pend_q;

    AST_DROP_NO_PEND: assert property (@(posedge clk) disable iff (rst)
        (owner == OWN_HW && go && no_queue && !pend_q) |=> !pend_q); // R8

    AST_SW_GO_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (owner == OWN_SW && !pend_q) |=> !pend_q); // R13

endmodule

// File: rtl/i2c_arb_fsm.sv
module i2c_arb_fsm
    import i2c_arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  arb_cfg_t cfg,
    input  sw_cmd_t  cmd,
    input  logic     hw_req,
    input  logic     pending,
    output owner_e   owner,
    output owner_e   owner_nx
);

    owner_e own_q;
    owner_e own_d;
    logic   intr_q;
    logic   intr_d;
    logic   sw_want;

    assign sw_want = cmd.go | pending;

    always_comb begin
        own_d  = own_q;
        intr_d = intr_q;
        unique case (own_q)
            OWN_IDLE: begin
                if (sw_want && (!hw_req || !hw_may_preempt(cfg.prio)))
                    own_d = OWN_SW;
                else if (hw_req)
                    own_d = OWN_HW;
            end
            OWN_SW: begin
                if (sw_lets_go(cmd)) begin
                    own_d = OWN_IDLE;
                end else if (hw_req && hw_may_preempt(cfg.prio)) begin
                    own_d  = OWN_HW;
                    intr_d = 1'b1;
                end
            end
            OWN_HW: begin
                if (!hw_req) begin
                    own_d  = ((intr_q && cfg.restart_en) || sw_want) ? OWN_SW : OWN_IDLE;
                    intr_d = 1'b0;
                end
            end
            default: begin
                own_d  = OWN_IDLE;
                intr_d = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q  <= OWN_IDLE;
            intr_q <= 1'b0;
        end else begin
            own_q  <= own_d;
            intr_q <= intr_d;
        end
    end

    assign owner    = own_q;
    assign owner_nx = own_d;

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (own_q == OWN_SW && cmd.done) |=> own_q == OWN_IDLE); // R3

    AST_PREEMPT: assert property (@(posedge clk) disable iff (rst)
        (own_q == OWN_SW && hw_req && cfg.prio == PRIO_NORMAL && !cmd.done && !cmd.sreset)
        |=> own_q == OWN_HW); // R4

    AST_HIGH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (own_q == OWN_SW && cfg.prio == PRIO_HIGH && !cmd.done && !cmd.sreset)
        |=> own_q == OWN_SW); // R5

    AST_RESTART: assert property (@(posedge clk) disable iff (rst)
        (own_q == OWN_HW && !hw_req && intr_q && cfg.restart_en) |=> own_q == OWN_SW); // R6

    AST_SRESET_HW: assert property (@(posedge clk) disable iff (rst)
        (own_q == OWN_HW && hw_req && cmd.sreset) |=> own_q == OWN_HW); // R10

endmodule

// File: rtl/i2c_arb_out.sv
module i2c_arb_out
    import i2c_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  owner_e             owner,
    input  owner_e             owner_nx,
    output logic [OWNER_W-1:0] status,
    output logic               grant_sw,
    output logic               grant_hw,
    output logic               start
);

    logic [OWNER_W-1:0] st_q;
    logic               gsw_q;
    logic               ghw_q;
    logic               start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= OWN_IDLE;
            gsw_q   <= 1'b0;
            ghw_q   <= 1'b0;
            start_q <= 1'b0;
        end else begin
            st_q    <= owner_nx;
            gsw_q   <= (owner_nx == OWN_SW);
            ghw_q   <= (owner_nx == OWN_HW);
            start_q <= (owner_nx == OWN_SW) && (owner != OWN_SW);
        end
    end

    assign status   = st_q;
    assign grant_sw = gsw_q;
    assign grant_hw = ghw_q;
    assign start    = start_q;

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (st_q == OWN_IDLE && !gsw_q && !ghw_q)); // R1

    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (rst)
        st_q != 2'd3); // R1

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({gsw_q, ghw_q})); // R11

    AST_GRANT_MATCH: assert property (@(posedge clk) disable iff (rst)
        gsw_q == (owner == OWN_SW)); // R11

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        start_q |=> !start_q); // R12

endmodule

// File: rtl/i2c_eng_arb.sv
module i2c_eng_arb
    import i2c_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sw_go,
    input  logic               sw_done,
    input  logic               sw_reset,
    input  logic               hw_req,
    input  logic               cfg_prio,
    input  logic               cfg_restart_en,
    input  logic               cfg_no_queue,
    output logic [OWNER_W-1:0] owner_status,
    output logic               grant_sw,
    output logic               grant_hw,
    output logic               eng_start
);

    arb_cfg_t cfg;
    sw_cmd_t  cmd;
    owner_e   owner;
    owner_e   owner_nx;
    logic     pending;

    assign cfg.prio       = prio_e'(cfg_prio);
    assign cfg.restart_en = cfg_restart_en;
    assign cfg.no_queue   = cfg_no_queue;
    assign cmd.go         = sw_go;
    assign cmd.done       = sw_done;
    assign cmd.sreset     = sw_reset;

    i2c_arb_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .cmd      (cmd),
        .hw_req   (hw_req),
        .pending  (pending),
        .owner    (owner),
        .owner_nx (owner_nx)
    );

    i2c_arb_req u_req (
        .clk      (clk),
        .rst      (rst),
        .go       (sw_go),
        .no_queue (cfg_no_queue),
        .owner    (owner),
        .owner_nx (owner_nx),
        .pending  (pending)
    );

    i2c_arb_out u_out (
        .clk      (clk),
        .rst      (rst),
        .owner    (owner),
        .owner_nx (owner_nx),
        .status   (owner_status),
        .grant_sw (grant_sw),
        .grant_hw (grant_hw),
        .start    (eng_start)
    );

endmodule

// File: tb/i2c_eng_arb_tb.sv
module i2c_eng_arb_tb;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sw_go = 1'b0, sw_done = 1'b0, sw_reset = 1'b0, hw_req = 1'b0;
    logic       cfg_prio = 1'b0, cfg_restart_en = 1'b0, cfg_no_queue = 1'b0;
    logic [1:0] owner_status;
    logic       grant_sw, grant_hw, eng_start;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    i2c_eng_arb u_dut (
        .clk(clk), .rst(rst), .sw_go(sw_go), .sw_done(sw_done), .sw_reset(sw_reset),
        .hw_req(hw_req), .cfg_prio(cfg_prio), .cfg_restart_en(cfg_restart_en),
        .cfg_no_queue(cfg_no_queue), .owner_status(owner_status), .grant_sw(grant_sw),
        .grant_hw(grant_hw), .eng_start(eng_start)
    );

    task automatic tick();
        @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic chk(input string rq, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d (prio=%0d restart=%0d noq=%0d)",
                     rq, got, exp, cfg_prio, cfg_restart_en, cfg_no_queue);
        end
    endtask

    // Owner code plus matching grants (R11).
    task automatic expect_st(input string rq, input int st);
        chk(rq, owner_status, st);
        chk({rq, "/R11 grant_sw"}, grant_sw, (st == 1) ? 1 : 0);
        chk({rq, "/R11 grant_hw"}, grant_hw, (st == 2) ? 1 : 0);
    endtask

    task automatic do_reset();
        sw_go = 0; sw_done = 0; sw_reset = 0; hw_req = 0;
        rst = 1;
        tick(); tick();
        rst = 0;
    endtask

    task automatic pulse_go();   sw_go = 1;    tick(); sw_go = 0;    endtask
    task automatic pulse_done(); sw_done = 1;  tick(); sw_done = 0;  endtask
    task automatic pulse_srst(); sw_reset = 1; tick(); sw_reset = 0; endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int exp4;
        tick();
        for (int cfgv = 0; cfgv < 8; cfgv++) begin
            cfg_prio       = cfgv[2];
            cfg_restart_en = cfgv[1];
            cfg_no_queue   = cfgv[0];
            do_reset();
            expect_st("R1 reset", 0);
            chk("R12 start after reset", eng_start, 0);

            // Software gains the engine.
            pulse_go();
            expect_st("R2 go from idle", 1);
            chk("R12 start strobe", eng_start, 1);
            tick();
            chk("R12 start single", eng_start, 0);

            // Hardware asks while software owns.
            hw_req = 1;
            tick();
            expect_st(cfg_prio ? "R5 no preempt" : "R4 preempt", cfg_prio ? 1 : 2);

            // Software go during that phase.
            pulse_go();
            expect_st(cfg_prio ? "R5 holds" : "R13/R8 go while hw", cfg_prio ? 1 : 2);

            // Hardware lets go.
            hw_req = 0;
            tick();
            if (cfg_prio) exp4 = 1;
            else          exp4 = (cfg_restart_en || !cfg_no_queue) ? 1 : 0;
            expect_st(cfg_prio ? "R5 sw kept" :
                      (cfg_restart_en ? "R6 restart" : (cfg_no_queue ? "R7/R8 dropped" : "R9 queued")),
                      exp4);
            chk("R12 start on restart", eng_start, (!cfg_prio && exp4 == 1) ? 1 : 0);

            pulse_done();
            expect_st("R3 done releases", 0);
            tick();
            expect_st("R8 nothing left pending", 0);

            // Simultaneous contention from idle.
            sw_go = 1; hw_req = 1;
            tick();
            sw_go = 0;
            expect_st("R2 contention", cfg_prio ? 1 : 2);
            if (cfg_prio) begin
                pulse_done();
                expect_st("R5 via idle", 0);
                tick();
                expect_st("R5 hw after idle", 2);
            end else begin
                tick();
                expect_st("R4 hw holds", 2);
            end
            hw_req = 0;
            tick();
            // At normal priority the contention go is held unless dropping is set (R9/R8).
            expect_st("R9/R8 after contention", (!cfg_prio && !cfg_no_queue) ? 1 : 0);
            pulse_done();
            expect_st("R3 idle again", 0);
        end

        // Soft reset only in software ownership (R10); done ignored elsewhere (R3).
        cfg_prio = 0; cfg_restart_en = 0; cfg_no_queue = 1;
        do_reset();
        pulse_srst();
        expect_st("R10 sreset idle", 0);
        pulse_done();
        expect_st("R3 done in idle ignored", 0);
        hw_req = 1;
        tick();
        expect_st("R4 hw from idle", 2);
        pulse_srst();
        expect_st("R10 sreset in hw", 2);
        pulse_done();
        expect_st("R3 done in hw ignored", 2);
        hw_req = 0;
        tick();
        expect_st("R7 hw release", 0);
        pulse_go();
        expect_st("R2 go", 1);
        pulse_srst();
        expect_st("R10 sreset in sw", 0);

        // Second go while software owns is not remembered (R13).
        cfg_no_queue = 0;
        pulse_go();
        expect_st("R2 go again", 1);
        pulse_go();
        expect_st("R13 go while sw", 1);
        chk("R12 no restrobe", eng_start, 0);
        pulse_done();
        expect_st("R13 released", 0);
        tick();
        expect_st("R13 not remembered", 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule